// File: doc/BRIEF.md
# Glass-Break Feature Extractor and Classifier

This block decides whether a burst of sound recorded after a trigger looks like breaking glass. Once a window is started it takes a fixed number of 10-bit converter codes, each with a signed sample from an external high-pass filter. For each code it removes the mid-scale offset and smooths the result with a four-tap moving average. It counts local maxima and sign changes of the smoothed signal. It also keeps a running sum of the positive part of the raw band and a second sum of the positive part of the high-pass band. Each sum is 16 bits wide and has its own counter of wrap-arounds.

When the last sample of the window has been taken, the block pulses a request to an external divider. The divider forms the band-energy ratio from the two sums and their wrap counts. It returns the integer part of the ratio, the fraction in quarters and a divide-by-zero flag. The block then applies three acceptance ranges: ratio, peak count and zero-crossing count. It issues a one-cycle done pulse either way. Only when all three ranges accept does it drive the LED and buzzer outputs for a fixed hold time. It then returns to the idle, waiting-for-trigger state.

The feature outputs keep their values until the next window is started. Starting a window clears them.

Top module: `gbreak_classifier`

## Requirements
- R1: While a window runs, each accepted code is converted to a signed value by subtracting 512. When that value is non-negative it is added to a 16-bit unsigned raw sum (`int_total`), and every carry out of this add increments `ovf_total` by one. Negative values leave both unchanged.
- R2: With each accepted code, a non-negative `hp_data` is added to a 16-bit unsigned high-pass sum (`int_hp`), and every carry out increments `ovf_hp`. A negative `hp_data` leaves both unchanged.
- R3: The smoothed value is the sum of the current signed sample and the three previous ones, shifted right arithmetically by 2. `peak_cnt` increments when the previous smoothed value is strictly greater than both the current smoothed value and the smoothed value before the previous one. It increments by at most one per sample.
- R4: `zero_cnt` increments when the previous and current smoothed values differ in sign, with zero counted as non-negative.
- R5: The window closes on the 2336th accepted sample. `div_req` is high for exactly the one cycle after that sample. Samples presented after that, while the block waits for the ratio, change no feature output.
- R6: Samples presented while no window is running change no feature output.
- R7: The ratio rule accepts only when `ratio_dz` is 0 and either the quotient lies in 2..6, or the quotient is 1 and `ratio_qtr` (the fraction in quarters, 0..3) is 3.
- R8: The peak rule accepts only `peak_cnt` in 160..319. The zero-crossing rule accepts only `zero_cnt` in 95..299.
- R9: In the cycle after `ratio_valid` is seen while waiting, `done` is high for one cycle. If all three rules accept, `led_on` and `buzz_on` rise in that same cycle and stay high for 16 cycles. Otherwise they stay low. The block then returns to idle.
- R10: After reset every output is 0. A `win_start` seen in idle clears the sample history, both counts, both sums and both wrap counters before the first sample of the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | Starts a new analysis window (honoured in idle) |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_code | input | 10 | Unsigned converter code, mid-scale 512 |
| hp_data | input | 16 | Signed high-pass filter output for the same sample |
| ratio_valid | input | 1 | Divider result is present this cycle |
| ratio_quot | input | 16 | Integer part of the band ratio |
| ratio_qtr | input | 2 | Fraction of the band ratio in quarters |
| ratio_dz | input | 1 | Divider saw a zero divisor |
| div_req | output | 1 | One-cycle pulse when the window has closed |
| int_total | output | 16 | Raw-band positive sum |
| ovf_total | output | 12 | Wrap count of the raw-band sum |
| int_hp | output | 16 | High-pass positive sum |
| ovf_hp | output | 12 | Wrap count of the high-pass sum |
| peak_cnt | output | 16 | Local maxima of the smoothed signal |
| zero_cnt | output | 16 | Sign changes of the smoothed signal |
| done | output | 1 | One-cycle pulse when a verdict is made |
| led_on | output | 1 | Alarm indicator drive |
| buzz_on | output | 1 | Alarm sounder drive |

## Verification
The assertions check on every cycle that:
- a sum's wrap counter moves exactly when that sum wraps, and both counts step by at most one;
- the features hold still whenever no sample is taken;
- `div_req` arrives after exactly the window length of accepted samples;
- `done` is a single pulse that follows the waiting state, and the alarm only rises together with it.

The bench scenarios are needed to show the values themselves. Several waveforms drive the counts and sums, with both sums wrapping, and each is compared against a model of the requirements. The scenarios also show the ratio boundaries at quotient 1 with three quarters and with two quarters, quotient 0, 6 and 7 and divide-by-zero, and the length of the alarm hold.

// File: rtl/gbk_pkg.sv
package gbk_pkg;

    localparam int ADC_W     = 10;
    localparam int MID_CODE  = 512;
    localparam int SMP_W     = ADC_W + 1;
    localparam int HP_W      = 16;
    localparam int ACC_W     = 16;
    localparam int OVF_W     = 12;
    localparam int CNT_W     = 16;
    localparam int Q_W       = 16;
    localparam int FRAC_W    = 2;
    localparam int AVG_TAPS  = 4;
    localparam int WIN_LEN   = 2336;
    localparam int HOLD_CYC  = 16;
    localparam int PEAK_LO   = 160;
    localparam int PEAK_HI   = 319;
    localparam int ZERO_LO   = 95;
    localparam int ZERO_HI   = 299;
    localparam int RATIO_LO  = 1;
    localparam int RATIO_HI  = 6;
    localparam int FRAC_MIN  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HOLD = 2'd3
    } gbk_state_e;

    typedef struct packed {
        logic ratio_ok;
        logic peak_ok;
        logic zero_ok;
    } gbk_verdict_t;

    // remove the mid-scale offset from a converter code
    function automatic logic signed [SMP_W-1:0] center_code(input logic [ADC_W-1:0] code);
        logic [SMP_W-1:0] diff;
        diff = {1'b0, code} - SMP_W'(MID_CODE);
        return $signed(diff);
    endfunction

    function automatic logic count_in_range(input logic [CNT_W-1:0] v,
                                            input int lo, input int hi);
        return (v >= CNT_W'(lo)) && (v <= CNT_W'(hi));
    endfunction

    function automatic logic ratio_accept(input logic [Q_W-1:0] q,
                                          input logic [FRAC_W-1:0] frac,
                                          input logic dz);
        logic whole_ok;
        logic edge_ok;
        whole_ok = (q > Q_W'(RATIO_LO)) && (q <= Q_W'(RATIO_HI));
        edge_ok  = (q == Q_W'(RATIO_LO)) && (frac >= FRAC_W'(FRAC_MIN));
        return !dz && (whole_ok || edge_ok);
    endfunction

endpackage

// File: rtl/gbk_smoother.sv
module gbk_smoother
    import gbk_pkg::*;
#(
    parameter int S_W   = SMP_W,
    parameter int C_W   = CNT_W,
    parameter int TAPS  = AVG_TAPS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  en,
    input  logic signed [S_W-1:0] smp,
    output logic [C_W-1:0]        peak_cnt,
    output logic [C_W-1:0]        zero_cnt
);

    localparam int SH    = $clog2(TAPS);
    localparam int SUM_W = S_W + SH;

    logic signed [S_W-1:0]   hist [TAPS-1];
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] sum_sh;
    logic signed [S_W-1:0]   avg;
    logic signed [S_W-1:0]   avg_p1;
    logic signed [S_W-1:0]   avg_p2;
    logic                    peak_hit;
    logic                    zero_hit;

    // delay line of past samples
    genvar g;
    generate
        for (g = 0; g < TAPS - 1; g++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    hist[g] <= '0;
                end else if (en) begin
                    if (g == 0) begin
                        hist[g] <= smp;
                    end else begin
                        hist[g] <= hist[(g == 0) ? 0 : g - 1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        sum = {{SH{smp[S_W-1]}}, smp};
        for (int i = 0; i < TAPS - 1; i++) begin
            sum = sum + {{SH{hist[i][S_W-1]}}, hist[i]};
        end
        sum_sh   = sum >>> SH;
        avg      = sum_sh[S_W-1:0];
        peak_hit = (avg_p1 > avg) && (avg_p1 > avg_p2);
        zero_hit = avg_p1[S_W-1] ^ avg[S_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            avg_p1   <= '0;
            avg_p2   <= '0;
            peak_cnt <= '0;
            zero_cnt <= '0;
        end else if (en) begin
            avg_p2   <= avg_p1;
            avg_p1   <= avg;
            peak_cnt <= peak_cnt + C_W'(peak_hit);
            zero_cnt <= zero_cnt + C_W'(zero_hit);
        end
    end

endmodule

// File: rtl/gbk_integrator.sv
module gbk_integrator
    import gbk_pkg::*;
#(
    parameter int IN_W = SMP_W,
    parameter int A_W  = ACC_W,
    parameter int O_W  = OVF_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   en,
    input  logic signed [IN_W-1:0] din,
    output logic [A_W-1:0]         acc,
    output logic [O_W-1:0]         ovf
);

    logic [A_W:0] addend;
    logic [A_W:0] total;
    logic         take;

    always_comb begin
        addend           = '0;
        addend[IN_W-1:0] = din;
        take             = en && !din[IN_W-1];
        total            = {1'b0, acc} + addend;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
            ovf <= '0;
        end else if (take) begin
            acc <= total[A_W-1:0];
            if (total[A_W]) begin
                ovf <= ovf + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gbk_ctrl.sv
module gbk_ctrl
    import gbk_pkg::*;
#(
    parameter int N_SMP  = WIN_LEN,
    parameter int N_HOLD = HOLD_CYC,
    parameter int C_W    = CNT_W,
    parameter int P_LO   = PEAK_LO,
    parameter int P_HI   = PEAK_HI,
    parameter int Z_LO   = ZERO_LO,
    parameter int Z_HI   = ZERO_HI
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_start,
    input  logic              smp_valid,
    input  logic              ratio_valid,
    input  logic [Q_W-1:0]    ratio_quot,
    input  logic [FRAC_W-1:0] ratio_qtr,
    input  logic              ratio_dz,
    input  logic [C_W-1:0]    peak_cnt,
    input  logic [C_W-1:0]    zero_cnt,
    output gbk_state_e        st,
    output logic              clr,
    output logic              acc_en,
    output logic              div_req,
    output logic              done,
    output logic              alarm
);

    localparam int SC_W = $clog2(N_SMP + 1);
    localparam int HC_W = $clog2(N_HOLD + 1);
    localparam logic [SC_W-1:0] SMP_LAST  = SC_W'(N_SMP - 1);
    localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(N_HOLD - 1);

    logic [SC_W-1:0] smp_cnt;
    logic [HC_W-1:0] hold_cnt;
    gbk_verdict_t    verdict;
    logic            all_ok;

    always_comb begin
        verdict.ratio_ok = ratio_accept(ratio_quot, ratio_qtr, ratio_dz);
        verdict.peak_ok  = count_in_range(peak_cnt, P_LO, P_HI);
        verdict.zero_ok  = count_in_range(zero_cnt, Z_LO, Z_HI);
        all_ok           = verdict.ratio_ok && verdict.peak_ok && verdict.zero_ok;
        clr              = (st == ST_IDLE) && win_start;
        acc_en           = (st == ST_RUN) && smp_valid;
        alarm            = (st == ST_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            smp_cnt  <= '0;
            hold_cnt <= '0;
            div_req  <= 1'b0;
            done     <= 1'b0;
        end else begin
            div_req <= 1'b0;
            done    <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (win_start) begin
                        st      <= ST_RUN;
                        smp_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (smp_valid) begin
                        if (smp_cnt == SMP_LAST) begin
                            st      <= ST_WAIT;
                            div_req <= 1'b1;
                        end else begin
                            smp_cnt <= smp_cnt + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (ratio_valid) begin
                        done <= 1'b1;
                        if (all_ok) begin
                            st       <= ST_HOLD;
                            hold_cnt <= HOLD_LAST;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        hold_cnt <= hold_cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gbreak_classifier.sv
module gbreak_classifier
    import gbk_pkg::*;
#(
    parameter int N_SMP  = WIN_LEN,
    parameter int N_HOLD = HOLD_CYC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   win_start,
    input  logic                   smp_valid,
    input  logic [ADC_W-1:0]       smp_code,
    input  logic signed [HP_W-1:0] hp_data,
    input  logic                   ratio_valid,
    input  logic [Q_W-1:0]         ratio_quot,
    input  logic [FRAC_W-1:0]      ratio_qtr,
    input  logic                   ratio_dz,
    output logic                   div_req,
    output logic [ACC_W-1:0]       int_total,
    output logic [OVF_W-1:0]       ovf_total,
    output logic [ACC_W-1:0]       int_hp,
    output logic [OVF_W-1:0]       ovf_hp,
    output logic [CNT_W-1:0]       peak_cnt,
    output logic [CNT_W-1:0]       zero_cnt,
    output logic                   done,
    output logic                   led_on,
    output logic                   buzz_on
);

    gbk_state_e              st;
    logic                    clr;
    logic                    acc_en;
    logic                    alarm;
    logic signed [SMP_W-1:0] smp_s;

    assign smp_s = center_code(smp_code);

    gbk_ctrl #(
        .N_SMP  (N_SMP),
        .N_HOLD (N_HOLD),
        .C_W    (CNT_W),
        .P_LO   (PEAK_LO),
        .P_HI   (PEAK_HI),
        .Z_LO   (ZERO_LO),
        .Z_HI   (ZERO_HI)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .win_start   (win_start),
        .smp_valid   (smp_valid),
        .ratio_valid (ratio_valid),
        .ratio_quot  (ratio_quot),
        .ratio_qtr   (ratio_qtr),
        .ratio_dz    (ratio_dz),
        .peak_cnt    (peak_cnt),
        .zero_cnt    (zero_cnt),
        .st          (st),
        .clr         (clr),
        .acc_en      (acc_en),
        .div_req     (div_req),
        .done        (done),
        .alarm       (alarm)
    );

    gbk_smoother #(
        .S_W  (SMP_W),
        .C_W  (CNT_W),
        .TAPS (AVG_TAPS)
    ) u_smooth (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .en       (acc_en),
        .smp      (smp_s),
        .peak_cnt (peak_cnt),
        .zero_cnt (zero_cnt)
    );

    gbk_integrator #(
        .IN_W (SMP_W),
        .A_W  (ACC_W),
        .O_W  (OVF_W)
    ) u_int_raw (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .en  (acc_en),
        .din (smp_s),
        .acc (int_total),
        .ovf (ovf_total)
    );

    gbk_integrator #(
        .IN_W (HP_W),
        .A_W  (ACC_W),
        .O_W  (OVF_W)
    ) u_int_hp (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .en  (acc_en),
        .din (hp_data),
        .acc (int_hp),
        .ovf (ovf_hp)
    );

    assign led_on  = alarm;
    assign buzz_on = alarm;

endmodule

// File: rtl/gbk_checker.sv
module gbk_checker
    import gbk_pkg::*;
#(
    parameter int N_SMP = WIN_LEN
) (
    input logic             clk,
    input logic             rst,
    input logic             win_start,
    input logic             smp_valid,
    input gbk_state_e       st,
    input logic             div_req,
    input logic             done,
    input logic             led_on,
    input logic [ACC_W-1:0] int_total,
    input logic [OVF_W-1:0] ovf_total,
    input logic [ACC_W-1:0] int_hp,
    input logic [OVF_W-1:0] ovf_hp,
    input logic [CNT_W-1:0] peak_cnt,
    input logic [CNT_W-1:0] zero_cnt
);

    localparam int WC_W = $clog2(N_SMP + 1) + 1;

    logic            taking;
    logic            starting;
    logic [WC_W-1:0] win_seen;

    assign taking   = (st == ST_RUN) && smp_valid;
    assign starting = (st == ST_IDLE) && win_start;

    always_ff @(posedge clk) begin
        if (rst || starting) begin
            win_seen <= '0;
        end else if (taking) begin
            win_seen <= win_seen + 1'b1;
        end
    end

    // R1
    raw_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (taking && !starting) |=>
            ((ovf_total != $past(ovf_total)) == (int_total < $past(int_total))));

    // R2
    hp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (taking && !starting) |=>
            ((ovf_hp != $past(ovf_hp)) == (int_hp < $past(int_hp))));

    // R3
    peak_step_chk: assert property (@(posedge clk) disable iff (rst)
        taking |=> (peak_cnt == $past(peak_cnt) || peak_cnt == $past(peak_cnt) + 1'b1));

    // R4
    zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        taking |=> (zero_cnt == $past(zero_cnt) || zero_cnt == $past(zero_cnt) + 1'b1));

    // R5
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(div_req) |-> (win_seen == WC_W'(N_SMP)));

    // R5
    div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        div_req |=> !div_req);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!taking && !starting) |=>
            ($stable(peak_cnt) && $stable(zero_cnt) && $stable(int_total) &&
             $stable(int_hp) && $stable(ovf_total) && $stable(ovf_hp)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st) == ST_WAIT));

    // R9
    alarm_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(led_on) |-> done);

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        starting |=> (peak_cnt == '0 && zero_cnt == '0 && int_total == '0 &&
                      int_hp == '0 && ovf_total == '0 && ovf_hp == '0));

endmodule

bind gbreak_classifier gbk_checker #(.N_SMP(N_SMP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .win_start (win_start),
    .smp_valid (smp_valid),
    .st        (st),
    .div_req   (div_req),
    .done      (done),
    .led_on    (led_on),
    .int_total (int_total),
    .ovf_total (ovf_total),
    .int_hp    (int_hp),
    .ovf_hp    (ovf_hp),
    .peak_cnt  (peak_cnt),
    .zero_cnt  (zero_cnt)
);

// File: tb/gbreak_classifier_tb.sv
module gbreak_classifier_tb;

    localparam int NW   = 2336;
    localparam int HOLD = 16;
    localparam int NROW = 9;

    typedef struct packed {
        logic [1:0]  pat;
        logic [15:0] hp_amp;
        logic [15:0] quot;
        logic [1:0]  qtr;
        logic        dz;
        logic        exp_alarm;
    } row_t;

    // pattern 0 passes both count rules; 1 has too many crossings,
    // 2 has no strict peaks, 3 never crosses zero
    localparam row_t ROWS [NROW] = '{
        '{2'd0, 16'd1000,  16'd3, 2'd0, 1'b0, 1'b1},
        '{2'd0, 16'd32767, 16'd1, 2'd3, 1'b0, 1'b1},
        '{2'd0, 16'd500,   16'd1, 2'd2, 1'b0, 1'b0},
        '{2'd0, 16'd500,   16'd6, 2'd0, 1'b0, 1'b1},
        '{2'd0, 16'd500,   16'd7, 2'd0, 1'b0, 1'b0},
        '{2'd0, 16'd500,   16'd0, 2'd3, 1'b0, 1'b0},
        '{2'd0, 16'd500,   16'd3, 2'd0, 1'b1, 1'b0},
        '{2'd1, 16'd20000, 16'd3, 2'd0, 1'b0, 1'b0},
        '{2'd2, 16'd700,   16'd3, 2'd0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_code = 10'd512;
    logic [15:0] hp_data = '0;
    logic        ratio_valid = 1'b0;
    logic [15:0] ratio_quot = '0;
    logic [1:0]  ratio_qtr = '0;
    logic        ratio_dz = 1'b0;
    logic        div_req;
    logic [15:0] int_total;
    logic [11:0] ovf_total;
    logic [15:0] int_hp;
    logic [11:0] ovf_hp;
    logic [15:0] peak_cnt;
    logic [15:0] zero_cnt;
    logic        done;
    logic        led_on;
    logic        buzz_on;

    int n_chk  = 0;
    int n_fail = 0;
    int e_peak, e_zero, e_it, e_ot, e_ih, e_oh;

    always #2 clk = ~clk;

    gbreak_classifier u_dut (
        .clk(clk), .rst(rst), .win_start(win_start), .smp_valid(smp_valid),
        .smp_code(smp_code), .hp_data(hp_data), .ratio_valid(ratio_valid),
        .ratio_quot(ratio_quot), .ratio_qtr(ratio_qtr), .ratio_dz(ratio_dz),
        .div_req(div_req), .int_total(int_total), .ovf_total(ovf_total),
        .int_hp(int_hp), .ovf_hp(ovf_hp), .peak_cnt(peak_cnt), .zero_cnt(zero_cnt),
        .done(done), .led_on(led_on), .buzz_on(buzz_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // signed sample value of a pattern, built from 4-sample blocks
    function automatic int smp_val(input int pat, input int n);
        int b;
        b = (n / 4) % 4;
        case (pat)
            0: return (b == 1) ? 40 : ((b == 3) ? -200 : 200);
            1: return ((n / 4) % 2 == 1) ? -200 : 200;
            2: return ((n / 8) % 2 == 1) ? -200 : 200;
            default: return (b == 1) ? 40 : ((b == 3) ? 20 : 200);
        endcase
    endfunction

    function automatic int hp_val(input int amp, input int n);
        return (n % 2 == 0) ? amp : -amp;
    endfunction

    // expected features from the requirements
    task automatic model(input int pat, input int amp);
        int x1, x2, x3, a1, a2, x, s, a, h;
        x1 = 0; x2 = 0; x3 = 0; a1 = 0; a2 = 0;
        e_peak = 0; e_zero = 0; e_it = 0; e_ot = 0; e_ih = 0; e_oh = 0;
        for (int n = 0; n < NW; n++) begin
            x = smp_val(pat, n);
            s = x + x1 + x2 + x3;
            a = s >>> 2;
            if (a1 > a && a1 > a2) e_peak++;
            if ((a1 < 0) != (a < 0)) e_zero++;
            a2 = a1; a1 = a;
            x3 = x2; x2 = x1; x1 = x;
            if (x >= 0) begin
                e_it = e_it + x;
                if (e_it > 65535) begin e_it = e_it - 65536; e_ot++; end
            end
            h = hp_val(amp, n);
            if (h >= 0) begin
                e_ih = e_ih + h;
                if (e_ih > 65535) begin e_ih = e_ih - 65536; e_oh++; end
            end
        end
    endtask

    task automatic feat_snapshot(output int f [6]);
        f[0] = int'(peak_cnt); f[1] = int'(zero_cnt); f[2] = int'(int_total);
        f[3] = int'(ovf_total); f[4] = int'(int_hp); f[5] = int'(ovf_hp);
    endtask

    task automatic run_row(input int idx);
        row_t r;
        int   hc;
        int   snap [6];
        int   now_f [6];
        r = ROWS[idx];
        model(int'(r.pat), int'(r.hp_amp));
        @(negedge clk) win_start = 1'b1;
        @(negedge clk) win_start = 1'b0;
        feat_snapshot(now_f);
        for (int k = 0; k < 6; k++) chk($sformatf("R10 clear at start row %0d f%0d", idx, k), now_f[k], 0);
        for (int n = 0; n < NW; n++) begin
            smp_valid = 1'b1;
            smp_code  = 10'(smp_val(int'(r.pat), n) + 512);
            hp_data   = 16'(hp_val(int'(r.hp_amp), n));
            @(negedge clk);
        end
        smp_valid = 1'b0;
        chk($sformatf("R5 div_req after window row %0d", idx), int'(div_req), 1);
        if (idx == 0) begin
            feat_snapshot(snap);
            for (int n = 0; n < 10; n++) begin
                smp_valid = 1'b1;
                smp_code  = 10'd1000;
                hp_data   = 16'd30000;
                @(negedge clk);
                chk("R5 div_req low while waiting", int'(div_req), 0);
            end
            smp_valid = 1'b0;
            feat_snapshot(now_f);
            for (int k = 0; k < 6; k++) chk($sformatf("R5 samples ignored while waiting f%0d", k), now_f[k], snap[k]);
            chk("R9 no done before ratio", int'(done), 0);
        end
        ratio_quot  = r.quot;
        ratio_qtr   = r.qtr;
        ratio_dz    = r.dz;
        ratio_valid = 1'b1;
        @(negedge clk);
        ratio_valid = 1'b0;
        chk($sformatf("R9 done pulse row %0d", idx), int'(done), 1);
        chk($sformatf("R3 peak count row %0d", idx), int'(peak_cnt), e_peak);
        chk($sformatf("R4 zero count row %0d", idx), int'(zero_cnt), e_zero);
        chk($sformatf("R1 raw sum row %0d", idx), int'(int_total), e_it);
        chk($sformatf("R1 raw wraps row %0d", idx), int'(ovf_total), e_ot);
        chk($sformatf("R2 hp sum row %0d", idx), int'(int_hp), e_ih);
        chk($sformatf("R2 hp wraps row %0d", idx), int'(ovf_hp), e_oh);
        chk($sformatf("R7 R8 alarm verdict row %0d", idx), int'(led_on), int'(r.exp_alarm));
        hc = 0;
        for (int c = 0; c < HOLD + 4; c++) begin
            if (led_on) hc++;
            if (led_on != buzz_on) chk("R9 buzzer follows led", int'(buzz_on), int'(led_on));
            @(negedge clk);
            if (c == 0) chk("R9 done lasts one cycle", int'(done), 0);
        end
        chk($sformatf("R9 alarm hold length row %0d", idx), hc, r.exp_alarm ? HOLD : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int snap [6];
        int now_f [6];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        feat_snapshot(now_f);
        for (int k = 0; k < 6; k++) chk($sformatf("R10 reset feature f%0d", k), now_f[k], 0);
        chk("R10 reset div_req", int'(div_req), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset led", int'(led_on), 0);
        chk("R10 reset buzzer", int'(buzz_on), 0);

        // samples before any window must not count
        for (int n = 0; n < 8; n++) begin
            smp_valid = 1'b1; smp_code = 10'd900; hp_data = 16'd4000;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        feat_snapshot(now_f);
        for (int k = 0; k < 6; k++) chk($sformatf("R6 idle after reset f%0d", k), now_f[k], 0);

        for (int i = 0; i < NROW; i++) begin
            run_row(i);
            if (i == 0) begin
                feat_snapshot(snap);
                for (int n = 0; n < 12; n++) begin
                    smp_valid = 1'b1; smp_code = 10'd100; hp_data = 16'd12345;
                    @(negedge clk);
                end
                smp_valid = 1'b0;
                feat_snapshot(now_f);
                for (int k = 0; k < 6; k++) chk($sformatf("R6 idle between windows f%0d", k), now_f[k], snap[k]);
                chk("R6 no alarm from idle samples", int'(led_on), 0);
            end
        end
        finish_run();
    end

endmodule